// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns an operand reference of a 16-bit real-mode segmented processor into a memory location. It works from a mode code, the register values and a displacement. From these it forms a 16-bit effective address (offset) and picks the segment that applies. It then adds the segment value, moved up four bit positions, to the offset. The result is a 20-bit physical address. An explicit segment override replaces the default segment choice when it is requested.

Alongside the address path, the block packs an immediate operand from two instruction bytes. All results are registered. They appear one cycle after an input strobe, together with a matching valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. All data outputs load only on `valid_i` and otherwise hold their last value.
- R2: After reset (`rst_ni` low), every output is zero.
- R3: Displacement size `disp_size_i`: 0 adds nothing. 1 adds `disp_i[7:0]` sign-extended to 16 bits. 2 or 3 adds all of `disp_i`.
- R4: Mode 0 (based) gives offset = selected base + displacement. `base_sel_i`=0 selects `base_a_i` with default segment 3 (data). `base_sel_i`=1 selects `base_b_i` with default segment 2 (stack).
- R5: Mode 1 (direct) and the unused codes 5..7 give offset = `disp_i` in full, with default segment 3 (data). `disp_size_i` has no effect in these modes.
- R6: Mode 2 (immediate) gives offset = `disp_i` in full, with default segment 1 (code).
- R7: Mode 3 (indexed) gives offset = selected index + displacement, with default segment 3. `idx_sel_i`=0 selects `idx_a_i` and 1 selects `idx_b_i`.
- R8: Mode 4 (based indexed) gives offset = base + index + displacement. The default segment follows the base, as in R4.
- R9: All offset sums wrap modulo 65536.
- R10: `phys_o` = (segment value × 16 + offset) mod 2^20. Segment codes are 0 extra, 1 code, 2 stack and 3 data.
- R11: When `ovr_en_i` is high, `seg_o` = `ovr_seg_i` in every mode, and `phys_o` uses that segment.
- R12: `imm_o` = {`imm_hi_i`, `imm_lo_i`} when `imm_wide_i` is high. Otherwise it is {8'h00, `imm_lo_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| valid_i | input | 1 | input strobe |
| mode_i | input | 3 | addressing mode code |
| base_sel_i | input | 1 | base choice: 0 data base, 1 stack base |
| idx_sel_i | input | 1 | index choice |
| base_a_i | input | 16 | data-side base register value |
| base_b_i | input | 16 | stack-side base register value |
| idx_a_i | input | 16 | first index register value |
| idx_b_i | input | 16 | second index register value |
| disp_size_i | input | 2 | displacement size code |
| disp_i | input | 16 | displacement or direct offset |
| ovr_en_i | input | 1 | segment override enable |
| ovr_seg_i | input | 2 | override segment code |
| seg_extra_i | input | 16 | extra segment value (code 0) |
| seg_code_i | input | 16 | code segment value (code 1) |
| seg_stack_i | input | 16 | stack segment value (code 2) |
| seg_data_i | input | 16 | data segment value (code 3) |
| imm_lo_i | input | 8 | immediate low byte |
| imm_hi_i | input | 8 | immediate high byte |
| imm_wide_i | input | 1 | 1: 16-bit immediate |
| valid_o | output | 1 | result valid |
| ea_o | output | 16 | effective address |
| seg_o | output | 2 | segment code used |
| phys_o | output | 20 | physical address |
| imm_o | output | 16 | packed immediate |

## Verification
Some behaviour is checked by the assertions on every cycle: the one-cycle valid timing, the holding of outputs between strobes, the priority of the override on the segment code, and the zero high byte of narrow immediates. The offset arithmetic itself can only be shown by the bench scenarios. That covers sign extension of negative short displacements, wrap of the offset past 65535, wrap of the 20-bit sum, and which default segment each mode and base choice yields.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned OFS_W = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned PHYS_W = OFS_W + SEG_SHIFT;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_SEG = 4;
  localparam int unsigned SEG_CW = $clog2(N_SEG);

  typedef enum logic [2:0] {
    AM_BASED  = 3'd0,
    AM_DIRECT = 3'd1,
    AM_IMMED  = 3'd2,
    AM_INDEX  = 3'd3,
    AM_BIDX   = 3'd4
  } amode_e;

  typedef enum logic [SEG_CW-1:0] {
    SG_EXTRA = 2'd0,
    SG_CODE  = 2'd1,
    SG_STACK = 2'd2,
    SG_DATA  = 2'd3
  } seg_e;
endpackage

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
  import seg_addr_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic              base_sel_i,
  input  logic              idx_sel_i,
  input  logic [OFS_W-1:0]  base_a_i,
  input  logic [OFS_W-1:0]  base_b_i,
  input  logic [OFS_W-1:0]  idx_a_i,
  input  logic [OFS_W-1:0]  idx_b_i,
  input  logic [1:0]        disp_size_i,
  input  logic [OFS_W-1:0]  disp_i,
  input  logic              ovr_en_i,
  input  logic [SEG_CW-1:0] ovr_seg_i,
  output logic [OFS_W-1:0]  ea_o,
  output logic [SEG_CW-1:0] seg_o
);
  logic [OFS_W-1:0] base_v, idx_v, disp_v;
  seg_e             dflt_seg, base_seg;

  assign base_v   = base_sel_i ? base_b_i : base_a_i;
  assign idx_v    = idx_sel_i ? idx_b_i : idx_a_i;
  assign base_seg = base_sel_i ? SG_STACK : SG_DATA;

  always_comb begin
    if (disp_size_i[1])      disp_v = disp_i;
    else if (disp_size_i[0]) disp_v = {{(OFS_W-BYTE_W){disp_i[BYTE_W-1]}}, disp_i[BYTE_W-1:0]};
    else                     disp_v = '0;
  end

  // sums are truncated to OFS_W bits: offset wraps modulo 2^16
  always_comb begin
    case (mode_i)
      AM_BASED:  begin ea_o = base_v + disp_v;         dflt_seg = base_seg; end
      AM_IMMED:  begin ea_o = disp_i;                  dflt_seg = SG_CODE;  end
      AM_INDEX:  begin ea_o = idx_v + disp_v;          dflt_seg = SG_DATA;  end
      AM_BIDX:   begin ea_o = base_v + idx_v + disp_v; dflt_seg = base_seg; end
      default:   begin ea_o = disp_i;                  dflt_seg = SG_DATA;  end
    endcase
  end

  assign seg_o = ovr_en_i ? ovr_seg_i : dflt_seg;
endmodule

// File: rtl/seg_phys_add.sv
module seg_phys_add
  import seg_addr_pkg::*;
(
  input  logic [SEG_CW-1:0]       seg_sel_i,
  input  logic [N_SEG*OFS_W-1:0]  seg_vals_i,
  input  logic [OFS_W-1:0]        ea_i,
  output logic [PHYS_W-1:0]       phys_o
);
  logic [OFS_W-1:0] seg_arr [N_SEG];
  logic [OFS_W-1:0] seg_v;

  for (genvar g = 0; g < N_SEG; g++) begin : g_unpack
    assign seg_arr[g] = seg_vals_i[g*OFS_W +: OFS_W];
  end

  assign seg_v  = seg_arr[seg_sel_i];
  assign phys_o = {seg_v, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_i};
endmodule

// File: rtl/seg_imm_pack.sv
module seg_imm_pack
  import seg_addr_pkg::*;
(
  input  logic [BYTE_W-1:0]   lo_i,
  input  logic [BYTE_W-1:0]   hi_i,
  input  logic                wide_i,
  output logic [2*BYTE_W-1:0] imm_o
);
  assign imm_o = {(wide_i ? hi_i : {BYTE_W{1'b0}}), lo_i};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [2:0]  mode_i,
  input  logic        base_sel_i,
  input  logic        idx_sel_i,
  input  logic [15:0] base_a_i,
  input  logic [15:0] base_b_i,
  input  logic [15:0] idx_a_i,
  input  logic [15:0] idx_b_i,
  input  logic [1:0]  disp_size_i,
  input  logic [15:0] disp_i,
  input  logic        ovr_en_i,
  input  logic [1:0]  ovr_seg_i,
  input  logic [15:0] seg_extra_i,
  input  logic [15:0] seg_code_i,
  input  logic [15:0] seg_stack_i,
  input  logic [15:0] seg_data_i,
  input  logic [7:0]  imm_lo_i,
  input  logic [7:0]  imm_hi_i,
  input  logic        imm_wide_i,
  output logic        valid_o,
  output logic [15:0] ea_o,
  output logic [1:0]  seg_o,
  output logic [19:0] phys_o,
  output logic [15:0] imm_o
);
  logic [OFS_W-1:0]  ea_d;
  logic [SEG_CW-1:0] seg_d;
  logic [PHYS_W-1:0] phys_d;
  logic [15:0]       imm_d;

  seg_ea_calc i_ea (
    .mode_i, .base_sel_i, .idx_sel_i, .base_a_i, .base_b_i, .idx_a_i, .idx_b_i,
    .disp_size_i, .disp_i, .ovr_en_i, .ovr_seg_i, .ea_o(ea_d), .seg_o(seg_d)
  );

  seg_phys_add i_phys (
    .seg_sel_i (seg_d),
    .seg_vals_i({seg_data_i, seg_stack_i, seg_code_i, seg_extra_i}),
    .ea_i      (ea_d),
    .phys_o    (phys_d)
  );

  seg_imm_pack i_imm (.lo_i(imm_lo_i), .hi_i(imm_hi_i), .wide_i(imm_wide_i), .imm_o(imm_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ea_o    <= '0;
      seg_o   <= '0;
      phys_o  <= '0;
      imm_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ea_o   <= ea_d;
        seg_o  <= seg_d;
        phys_o <= phys_d;
        imm_o  <= imm_d;
      end
    end
  end

  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  a_r1_valid_low:  assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o);
  a_r1_hold:       assert property (@(posedge clk_i) disable iff (!rst_ni)
                     !valid_i |=> ($stable(phys_o) && $stable(ea_o) && $stable(seg_o) && $stable(imm_o)));
  a_r11_override:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (valid_i && ovr_en_i) |=> (seg_o == $past(ovr_seg_i)));
  a_r12_narrow:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (valid_i && !imm_wide_i) |=> (imm_o[15:8] == 8'h00));
endmodule

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        valid = 0, bsel = 0, isel = 0, ovr_en = 0, wide = 0;
  logic [2:0]  mode = 0;
  logic [1:0]  dsz = 0, ovr_seg = 0;
  logic [15:0] ba = 0, bb = 0, ia = 0, ib = 0, disp = 0, s_e = 0, s_c = 0, s_s = 0, s_d = 0;
  logic [7:0]  lo = 0, hi = 0;
  logic        v_o;
  logic [15:0] ea_o, imm_o;
  logic [1:0]  seg_o;
  logic [19:0] phys_o;

  seg_addr_gen i_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .base_sel_i(bsel),
    .idx_sel_i(isel), .base_a_i(ba), .base_b_i(bb), .idx_a_i(ia), .idx_b_i(ib),
    .disp_size_i(dsz), .disp_i(disp), .ovr_en_i(ovr_en), .ovr_seg_i(ovr_seg),
    .seg_extra_i(s_e), .seg_code_i(s_c), .seg_stack_i(s_s), .seg_data_i(s_d),
    .imm_lo_i(lo), .imm_hi_i(hi), .imm_wide_i(wide),
    .valid_o(v_o), .ea_o(ea_o), .seg_o(seg_o), .phys_o(phys_o), .imm_o(imm_o)
  );

  int total = 0, bad = 0;
  int x_v = 0, x_ea = 0, x_seg = 0, x_phys = 0, x_imm = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: computes from requirements using integer arithmetic
  task automatic model();
    int b, ix, d, off, sg, sv;
    b  = bsel ? int'(bb) : int'(ba);
    ix = isel ? int'(ib) : int'(ia);
    if (dsz >= 2)      d = int'(disp);
    else if (dsz == 1) d = (disp[7:0] >= 8'h80) ? int'(disp[7:0]) - 256 : int'(disp[7:0]);
    else               d = 0;
    case (mode)
      3'd0:    begin off = b + d;      sg = bsel ? 2 : 3; end
      3'd2:    begin off = int'(disp); sg = 1; end
      3'd3:    begin off = ix + d;     sg = 3; end
      3'd4:    begin off = b + ix + d; sg = bsel ? 2 : 3; end
      default: begin off = int'(disp); sg = 3; end
    endcase
    off = ((off % 65536) + 65536) % 65536;
    if (ovr_en) sg = int'(ovr_seg);
    sv = (sg == 0) ? int'(s_e) : (sg == 1) ? int'(s_c) : (sg == 2) ? int'(s_s) : int'(s_d);
    x_ea = off; x_seg = sg;
    x_phys = (sv * 16 + off) % 1048576;
    x_imm = wide ? (int'(hi) * 256 + int'(lo)) : int'(lo);
  endtask

  // compare at negedge, then drive next stimulus
  task automatic step(string req);
    @(negedge clk);
    chk({req, " R1 valid"}, int'(v_o), x_v);
    chk({req, " ea"}, int'(ea_o), x_ea);
    chk({req, " R11 seg"}, int'(seg_o), x_seg);
    chk({req, " R10 phys"}, int'(phys_o), x_phys);
    chk({req, " R12 imm"}, int'(imm_o), x_imm);
  endtask

  task automatic apply(logic v);
    valid = v;
    if (v) model();
    x_v = v;
  endtask

  task automatic setregs(logic [2:0] m, logic bs, logic is, logic [1:0] ds, logic [15:0] dp);
    mode = m; bsel = bs; isel = is; dsz = ds; disp = dp;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    s_e = 16'h1000; s_c = 16'h2000; s_s = 16'h3000; s_d = 16'h4000;
    ba = 16'h0010; bb = 16'h0200; ia = 16'h0003; ib = 16'h0040;
    repeat (3) @(negedge clk);
    step("R2 reset");
    rst_n = 1;

    // R4 based, data base, 8-bit negative displacement (R3)
    setregs(3'd0, 0, 0, 2'd1, 16'h1280); apply(1); step("R4 R3");
    // R4 based, stack base, no displacement
    setregs(3'd0, 1, 0, 2'd0, 16'h7777); apply(1); step("R4");
    // R3 16-bit displacement, code 3 treated as full
    setregs(3'd0, 0, 0, 2'd3, 16'h1234); apply(1); step("R3");
    // R5 direct ignores disp size
    setregs(3'd1, 1, 0, 2'd1, 16'hABCD); apply(1); step("R5");
    setregs(3'd6, 1, 0, 2'd0, 16'h0042); apply(1); step("R5 unused");
    // R6 immediate, wide and narrow (R12)
    lo = 8'h34; hi = 8'h12; wide = 1;
    setregs(3'd2, 0, 0, 2'd0, 16'h0100); apply(1); step("R6 R12");
    wide = 0;
    setregs(3'd2, 0, 0, 2'd0, 16'h0101); apply(1); step("R6 R12 narrow");
    // R7 indexed both index selects
    setregs(3'd3, 1, 0, 2'd1, 16'h0005); apply(1); step("R7");
    setregs(3'd3, 0, 1, 2'd2, 16'h0100); apply(1); step("R7");
    // R8 based indexed both bases
    setregs(3'd4, 0, 1, 2'd1, 16'h00FF); apply(1); step("R8");
    setregs(3'd4, 1, 0, 2'd2, 16'h0010); apply(1); step("R8");
    // R9 offset wrap
    ba = 16'hFFF0; ia = 16'h0020;
    setregs(3'd4, 0, 0, 2'd1, 16'h0005); apply(1); step("R9");
    // R10 20-bit wrap
    s_d = 16'hFFFF;
    setregs(3'd1, 0, 0, 2'd0, 16'hFFFF); apply(1); step("R10 wrap");
    // R11 override in every mode
    ovr_en = 1;
    for (int m = 0; m < 5; m++) begin
      ovr_seg = 2'(m);
      setregs(3'(m), 1, 0, 2'd1, 16'h0080); apply(1); step("R11");
    end
    ovr_en = 0;
    // R1 hold: inputs change without strobe
    setregs(3'd0, 1, 1, 2'd2, 16'h5555); apply(0); step("R1 hold");
    ba = 16'h9999; apply(0); step("R1 hold");
    // random
    for (int n = 0; n < 400; n++) begin
      mode = 3'($urandom_range(0, 7)); bsel = 1'($urandom); isel = 1'($urandom);
      dsz = 2'($urandom); disp = 16'($urandom); ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
      ba = 16'($urandom); bb = 16'($urandom); ia = 16'($urandom); ib = 16'($urandom);
      s_e = 16'($urandom); s_c = 16'($urandom); s_s = 16'($urandom); s_d = 16'($urandom);
      lo = 8'($urandom); hi = 8'($urandom); wide = 1'($urandom);
      apply(1'($urandom_range(0, 3) != 0)); step("R8 R10 random");
    end
    apply(0); step("R1 end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule